// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Slave

This block sits behind the two-wire serial control port of an audio fader and tone-control core. It watches SCL and SDA with the system clock and accepts only write transfers aimed at one fixed device address. It turns the bytes of each transfer into updates of a bank of eight 8-bit control registers. Those registers feed the volume and loudness, four output attenuator, bass, treble and source/mute switch settings of the audio path.

A transfer is built as follows. The master sends a START, the address byte and a subaddress byte, then one or more data bytes, and ends with a STOP. The slave acknowledges each accepted byte by pulling SDA low through an open-drain enable. The low three subaddress bits choose the first register. Each later data byte goes to the next register, and the index wraps from 7 back to 0. Each stored byte also produces a one-cycle strobe that carries the register index and the data. Downstream logic uses a strobe for index 7 to restart its mute timeout.

Top module: `snd_fader_i2c_wr`

## Requirements
- R1: While reset is active, every register reads 0x00, `sda_oe_o` is 0 and `wr_stb_o` is 0.
- R2: An address byte of 0x80 (7-bit address 0x40, write bit 0) is acknowledged. Acknowledge means `sda_oe_o` = 1 while SCL is high during the ninth clock of the byte.
- R3: An address byte with a different address, or with bit 0 (read) set, is not acknowledged. After it, no byte is acknowledged or stored until the next START.
- R4: The subaddress byte is acknowledged. Its bits 2:0 select the register for the first data byte, and bits 7:3 have no effect.
- R5: Each data byte is acknowledged and written to the selected register. It also produces a `wr_stb_o` pulse one cycle long, with `wr_idx_o` set to that register and `wr_data_o` set to the byte.
- R6: After each data byte the register index advances by one, so a burst fills consecutive registers and wraps from 7 to 0.
- R7: A STOP in the middle of a byte discards the partial byte: no strobe is produced and no register changes.
- R8: A repeated START, after either an acknowledged or a rejected address byte, restarts decoding at the address byte.
- R9: A register changes only in the cycle after a write strobe.
- R10: Register k appears on `regs_o[8k+7:8k]`. Index order: 0 volume/loudness, 1 front-right fader, 2 front-left fader, 3 rear-right fader, 4 rear-left fader, 5 bass, 6 treble, 7 switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| wr_stb_o | output | 1 | One-cycle pulse per stored data byte |
| wr_idx_o | output | 3 | Register index of the stored byte |
| wr_data_o | output | 8 | Stored byte |
| regs_o | output | 64 | All eight registers, register k in bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: device address 0x40, eight registers and a two-stage synchronizer. With eight registers, a four-byte burst that starts at index 6 crosses the wrap from 7 to 0. With address 0x40, a single wrong address bit and a set read bit each give a rejection case. The bench drives the bus at eight system clocks per quarter bit, so the edges seen through the synchronizer stay well apart.

// File: rtl/snd_i2c_pkg.sv
package snd_i2c_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_ff[i] <= 1'b1;
        sda_ff[i] <= 1'b1;
      end else if (i == 0) begin
        scl_ff[i] <= scl_i;
        sda_ff[i] <= sda_i;
      end else begin
        scl_ff[i] <= scl_ff[(i == 0) ? 0 : i-1];
        sda_ff[i] <= sda_ff[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import snd_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40,
  parameter int         IDX_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [3:0] FULL = 4'(BYTE_W);

  bus_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  ptr_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (state_q inside {ST_ADDR, ST_SUB, ST_DATA}) begin
        if (scl_rise_i && !oe_q && cnt_q != FULL) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall_i && oe_q) begin
          oe_q <= 1'b0;  // end of ack clock
        end else if (scl_fall_i && cnt_q == FULL) begin
          cnt_q <= '0;
          unique case (state_q)
            ST_ADDR: begin
              if (sh_q == {DEV_ADDR, 1'b0}) begin
                oe_q    <= 1'b1;
                state_q <= ST_SUB;
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_SUB: begin
              ptr_q   <= sh_q[IDX_W-1:0];
              oe_q    <= 1'b1;
              state_q <= ST_DATA;
            end
            default: begin
              wr_stb_o  <= 1'b1;
              wr_idx_o  <= ptr_q;
              wr_data_o <= sh_q;
              ptr_q     <= ptr_q + 1'b1;
              oe_q      <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [REG_W-1:0]          data_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[k*REG_W +: REG_W] <= '0;
      else if (wr_i && idx_i == IDX_W'(k))
        regs_o[k*REG_W +: REG_W] <= data_i;
    end
  end
endmodule

// File: rtl/snd_fader_i2c_wr.sv
module snd_fader_i2c_wr #(
  parameter logic [6:0] DEV_ADDR    = 7'h40,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        REG_W       = snd_i2c_pkg::BYTE_W,
  localparam int        IDX_W       = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe_o,
  output logic                      wr_stb_o,
  output logic [IDX_W-1:0]          wr_idx_o,
  output logic [REG_W-1:0]          wr_data_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_wr_engine #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_eng (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev),
    .sda_oe_o, .wr_stb_o, .wr_idx_o, .wr_data_o
  );

  ctrl_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
    .clk_i, .rst_ni, .wr_i(wr_stb_o), .idx_i(wr_idx_o),
    .data_i(wr_data_o), .regs_o
  );
endmodule

// File: rtl/snd_fader_i2c_wr_chk.sv
module snd_fader_i2c_wr_chk #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8,
  parameter int IDX_W    = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      sda_oe_o,
  input logic                      wr_stb_o,
  input logic [IDX_W-1:0]          wr_idx_o,
  input logic [REG_W-1:0]          wr_data_o,
  input logic [NUM_REGS*REG_W-1:0] regs_o
);
  // R5
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  // R5
  stb_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> sda_oe_o);

  // R9
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_stb_o) |-> $stable(regs_o));

  // R10
  reg_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> regs_o[32'($past(wr_idx_o))*REG_W +: REG_W] == $past(wr_data_o));
endmodule

bind snd_fader_i2c_wr snd_fader_i2c_wr_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i, .rst_ni, .sda_oe_o, .wr_stb_o, .wr_idx_o, .wr_data_o, .regs_o
);

// File: tb/tb_snd_fader_i2c_wr.sv
module tb_snd_fader_i2c_wr;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NV = 8;
  // {subaddress, data}
  localparam logic [15:0] VEC [NV] = '{
    16'h00_1F, 16'h01_22, 16'hF9_2D, 16'h02_37,
    16'h03_05, 16'h04_7F, 16'hAD_C3, 16'h07_81
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_stb;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;
  logic [63:0] regs;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  snd_fader_i2c_wr dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .regs_o(regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, stb_cnt = 0;
  logic [2:0] last_idx = '0;
  logic [7:0] last_data = '0;
  logic [7:0] exp_regs [8];
  bit done = 1'b0;

  always @(posedge clk) if (wr_stb) begin
    stb_cnt   <= stb_cnt + 1;
    last_idx  <= wr_idx;
    last_data <= wr_data;
  end

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;  // also repeated start
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq; scl_m = 1'b1; wq; scl_m = 1'b0; wq;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq; scl_m = 1'b1; wq;
    ack = sda_oe;
    scl_m = 1'b0; wq;
  endtask

  task automatic check_regs(string req);
    for (int k = 0; k < 8; k++) chk(req, int'(regs[k*8 +: 8]), int'(exp_regs[k]), "register");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic ack;
    int s0;
    for (int k = 0; k < 8; k++) exp_regs[k] = 8'h00;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", int'(regs == 64'h0), 1, "regs zero");
    chk("R1", int'(sda_oe), 0, "sda_oe");
    chk("R1", int'(wr_stb), 0, "wr_stb");
    rst_n = 1'b1;
    wq;

    // R2 R4 R5 R10 single writes from the table
    for (int v = 0; v < NV; v++) begin
      s0 = stb_cnt;
      bus_start;
      send_byte(8'h80, ack);        chk("R2", int'(ack), 1, "addr ack");
      send_byte(VEC[v][15:8], ack); chk("R4", int'(ack), 1, "sub ack");
      send_byte(VEC[v][7:0], ack);  chk("R5", int'(ack), 1, "data ack");
      bus_stop;
      chk("R5", stb_cnt - s0, 1, "strobe count");
      chk("R4", int'(last_idx), int'(VEC[v][10:8]), "strobe index");
      chk("R5", int'(last_data), int'(VEC[v][7:0]), "strobe data");
      exp_regs[VEC[v][10:8]] = VEC[v][7:0];
      check_regs("R10");
    end

    // R6 burst wrapping across register 7
    s0 = stb_cnt;
    bus_start;
    send_byte(8'h80, ack);
    send_byte(8'h06, ack);
    for (int j = 0; j < 4; j++) begin
      send_byte(8'h11 * (j + 1), ack);
      chk("R6", int'(ack), 1, "burst ack");
      exp_regs[(6 + j) % 8] = 8'(8'h11 * (j + 1));
    end
    bus_stop;
    chk("R6", stb_cnt - s0, 4, "burst strobes");
    chk("R6", int'(last_idx), 1, "last index after wrap");
    check_regs("R6");

    // R3 wrong address
    s0 = stb_cnt;
    bus_start;
    send_byte(8'h82, ack); chk("R3", int'(ack), 0, "wrong addr nack");
    send_byte(8'h00, ack); chk("R3", int'(ack), 0, "skip sub nack");
    send_byte(8'hEE, ack); chk("R3", int'(ack), 0, "skip data nack");
    bus_stop;
    // R3 read bit
    bus_start;
    send_byte(8'h81, ack); chk("R3", int'(ack), 0, "read nack");
    send_byte(8'h00, ack); chk("R3", int'(ack), 0, "read skip nack");
    bus_stop;
    chk("R3", stb_cnt - s0, 0, "no strobes");
    check_regs("R3");

    // R7 stop inside a data byte
    s0 = stb_cnt;
    bus_start;
    send_byte(8'h80, ack);
    send_byte(8'h03, ack);
    send_bits(8'h5A, 4);
    bus_stop;
    chk("R7", stb_cnt - s0, 0, "partial byte strobes");
    check_regs("R7");

    // R8 repeated start after accepted address
    s0 = stb_cnt;
    bus_start;
    send_byte(8'h80, ack);
    send_byte(8'h02, ack);
    bus_start;
    send_byte(8'h80, ack); chk("R8", int'(ack), 1, "restart addr ack");
    send_byte(8'h05, ack);
    send_byte(8'hA5, ack);
    bus_stop;
    exp_regs[5] = 8'hA5;
    chk("R8", stb_cnt - s0, 1, "restart strobes");
    chk("R8", int'(last_idx), 5, "restart index");
    check_regs("R8");

    // R8 repeated start after rejected address
    s0 = stb_cnt;
    bus_start;
    send_byte(8'h82, ack); chk("R8", int'(ack), 0, "reject before restart");
    bus_start;
    send_byte(8'h80, ack); chk("R8", int'(ack), 1, "ack after restart");
    send_byte(8'h04, ack);
    send_byte(8'h3C, ack);
    bus_stop;
    exp_regs[4] = 8'h3C;
    chk("R8", stb_cnt - s0, 1, "strobes after restart");
    check_regs("R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule